// File: doc/BRIEF.md
# Oversampled Serial Transmitter with Clear-to-Send Gating

This block turns parallel data words into an asynchronous serial stream on one output line. Words arrive over a valid/ready handshake, normally from a transmit FIFO in front of the block. Each accepted word is sent as one frame: a low start bit, the data bits, an optional parity bit, and a high stop period. The configuration inputs set the frame layout: the data width, which end of the word goes first, the parity mode and the stop length in half-bit steps.

All bit timing counts pulses of a single-cycle enable `os_tick`. An external baud divider produces that enable at the oversampling rate. Each bit lasts a programmable number of those pulses, and 12 is a common choice.

An optional clear-to-send input, with selectable polarity, holds back the start of a new frame. It never cuts short a frame that is already on the line. The `tx_complete` flag reports that no word is waiting at the input and no frame is in flight.

Top module: `utx_core`

## Requirements
- R1: After reset, `tx_out` is 1. While no frame is in flight, `tx_out` stays 1 and `in_ready` is 1 whenever sending is allowed (see R8).
- R2: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only with no frame in flight and sending allowed, and it stays 0 until the frame ends. The cycle after the last stop segment ends, the block is idle again.
- R3: `tx_out` goes to 0 on the accepting edge (the start bit). It then shows the data bits, then the parity bit if parity is on, then 1 for the stop period. The start bit, each data bit and the parity bit each last `cfg_os` pulses of `os_tick`, counted from the edge after the segment began.
- R4: `cfg_width` sets the number of data bits, from 4 to 16. Values below 4 act as 4, and values above 16 act as 16.
- R5: `cfg_msb_first`=0 sends bit 0 of `in_data` first. `cfg_msb_first`=1 sends bit `width-1` first. Bits at or above the width are never sent.
- R6: `cfg_parity` encoding: 2'b00 or 2'b01 means no parity bit, 2'b10 means even parity, 2'b11 means odd parity. With even parity the number of ones across data and parity is even. With odd parity that number is odd.
- R7: The stop period is `cfg_stop_half`+1 half-bits, which is 1 to 4. Each half-bit lasts floor(`cfg_os`/2) pulses. A `cfg_os` below 2 acts as 2.
- R8: With `cfg_cts_en`=1, sending is allowed only while `cts_in` is active. `cfg_cts_low`=1 makes 0 the active level, and `cfg_cts_low`=0 makes 1 the active level. With `cfg_cts_en`=0, sending is always allowed. A change of `cts_in` after a frame has started does not alter that frame.
- R9: `tx_complete` is 1 exactly when no frame is in flight and `in_valid` is 0.
- R10: Timing advances only on edges where `os_tick` is 1. `tx_out` changes only on such edges, except at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling-rate enable pulse |
| in_valid | input | 1 | Input word present |
| in_data | input | DATA_MAX | Input word |
| in_ready | output | 1 | Block can take a word |
| cfg_width | input | WIDTH_BITS | Data bits per frame |
| cfg_msb_first | input | 1 | 1 sends the most significant bit first |
| cfg_parity | input | 2 | Parity mode, as in R6 |
| cfg_stop_half | input | 2 | Stop length in half-bits, minus one |
| cfg_os | input | OS_BITS | `os_tick` pulses per bit |
| cfg_cts_en | input | 1 | Enable clear-to-send gating |
| cfg_cts_low | input | 1 | 1 makes `cts_in` active-low |
| cts_in | input | 1 | Clear-to-send input |
| tx_out | output | 1 | Serial output line |
| tx_complete | output | 1 | Nothing pending and nothing in flight |

## Verification
A behavioural model turns each word into a list of line levels and durations and is compared with the outputs on every cycle. The model is run with several groups of inputs:
- Alternating and uniform data words in both bit orders separate a reversed or shifted data path from a correct one.
- Words with even and odd numbers of ones under both parity senses expose an inverted or missing parity bit.
- Narrow, wide and out-of-range widths, together with all four stop lengths at an odd and an undersized `cfg_os`, test the clamping and the half-bit arithmetic.
- A sparse `os_tick`, and `cts_in` toggled before and during a frame under both polarities, separate the enable and the flow-control gating from free-running timing.

// File: rtl/utx_pkg.sv
package utx_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP
   } utx_phase_t;

   localparam int MIN_WIDTH  = 4;
   localparam int MIN_OS     = 2;
endpackage

// File: rtl/utx_order.sv
module utx_order #(
   parameter int DATA_MAX   = 16,
   parameter int WIDTH_BITS = 5
) (
   input  logic [DATA_MAX-1:0]   data,
   input  logic [WIDTH_BITS-1:0] width,
   input  logic                  msb_first,
   output logic [DATA_MAX-1:0]   ordered,
   output logic                  ones_odd
);
   localparam int IB = $clog2(DATA_MAX);

   // Puts the word in send order (bit 0 goes out first) and reduces its parity.
   always_comb begin
      ordered  = '0;
      ones_odd = 1'b0;
      for (int i = 0; i < DATA_MAX; i++) begin
         if (i < int'(width)) begin
            if (msb_first) ordered[i] = data[IB'(int'(width) - 1 - i)];
            else           ordered[i] = data[i];
            ones_odd = ones_odd ^ data[i];
         end
      end
   end
endmodule

// File: rtl/utx_seg_timer.sv
module utx_seg_timer #(
   parameter int OS_BITS = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               os_tick,
   input  logic [OS_BITS-1:0] seg_len,
   output logic               seg_done
);
   logic [OS_BITS-1:0] cnt_q;

   assign seg_done = os_tick && !clr && (cnt_q == seg_len - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr || seg_done) cnt_q <= '0;
      else if (os_tick)              cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/utx_core.sv
module utx_core
   import utx_pkg::*;
#(
   parameter int DATA_MAX    = 16,
   parameter int WIDTH_BITS  = 5,
   parameter int OS_BITS     = 6,
   parameter int CTS_PRESENT = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  os_tick,
   input  logic                  in_valid,
   input  logic [DATA_MAX-1:0]   in_data,
   output logic                  in_ready,
   input  logic [WIDTH_BITS-1:0] cfg_width,
   input  logic                  cfg_msb_first,
   input  logic [1:0]            cfg_parity,
   input  logic [1:0]            cfg_stop_half,
   input  logic [OS_BITS-1:0]    cfg_os,
   input  logic                  cfg_cts_en,
   input  logic                  cfg_cts_low,
   input  logic                  cts_in,
   output logic                  tx_out,
   output logic                  tx_complete
);
   // Elaboration-time parameter checks
   if (DATA_MAX < MIN_WIDTH || DATA_MAX > 16) begin : g_bad_data
      $error("utx_core: DATA_MAX must lie in 4..16");
   end
   if ((1 << WIDTH_BITS) <= DATA_MAX) begin : g_bad_wbits
      $error("utx_core: WIDTH_BITS too small for DATA_MAX");
   end
   if (OS_BITS < 2) begin : g_bad_os
      $error("utx_core: OS_BITS must be at least 2");
   end

   utx_phase_t            phase_q;
   logic [DATA_MAX-1:0]   sh_q;
   logic [WIDTH_BITS-1:0] w_q, idx_q, w_eff;
   logic [OS_BITS-1:0]    os_q, os_eff, seg_len;
   logic [2:0]            stop_left_q;
   logic                  par_q, par_en_q, tx_q;
   logic                  cts_ok, accept, seg_done;
   logic [DATA_MAX-1:0]   ordered;
   logic                  ones_odd;
   logic                  cts_feature;

   // Flow-control variant
   if (CTS_PRESENT != 0) begin : g_cts
      assign cts_ok = !cfg_cts_en || (cts_in ^ cfg_cts_low);
   end else begin : g_no_cts
      logic unused_cts;
      assign unused_cts = ^{cts_in, cfg_cts_en, cfg_cts_low};
      assign cts_ok     = 1'b1;
   end
   assign cts_feature = (CTS_PRESENT != 0);

   // Clamp out-of-range configuration
   always_comb begin
      if (cfg_width < WIDTH_BITS'(MIN_WIDTH))     w_eff = WIDTH_BITS'(MIN_WIDTH);
      else if (cfg_width > WIDTH_BITS'(DATA_MAX)) w_eff = WIDTH_BITS'(DATA_MAX);
      else                                        w_eff = cfg_width;
      os_eff = (cfg_os < OS_BITS'(MIN_OS)) ? OS_BITS'(MIN_OS) : cfg_os;
   end

   assign in_ready    = (phase_q == PH_IDLE) && cts_ok;
   assign accept      = in_valid && in_ready;
   assign tx_complete = (phase_q == PH_IDLE) && !in_valid;
   assign tx_out      = tx_q;
   assign seg_len     = (phase_q == PH_STOP) ? (os_q >> 1) : os_q;

   utx_order #(.DATA_MAX(DATA_MAX), .WIDTH_BITS(WIDTH_BITS)) u_order (
      .data      (in_data),
      .width     (w_eff),
      .msb_first (cfg_msb_first),
      .ordered   (ordered),
      .ones_odd  (ones_odd)
   );

   utx_seg_timer #(.OS_BITS(OS_BITS)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (phase_q == PH_IDLE),
      .os_tick  (os_tick),
      .seg_len  (seg_len),
      .seg_done (seg_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         tx_q        <= 1'b1;
         sh_q        <= '0;
         w_q         <= WIDTH_BITS'(MIN_WIDTH);
         idx_q       <= '0;
         os_q        <= OS_BITS'(MIN_OS);
         stop_left_q <= 3'd1;
         par_q       <= 1'b0;
         par_en_q    <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (accept) begin
               phase_q     <= PH_START;
               tx_q        <= 1'b0;
               sh_q        <= ordered;
               par_q       <= ones_odd ^ cfg_parity[0];
               par_en_q    <= cfg_parity[1];
               w_q         <= w_eff;
               os_q        <= os_eff;
               stop_left_q <= {1'b0, cfg_stop_half} + 3'd1;
               idx_q       <= '0;
            end
            PH_START: if (seg_done) begin
               phase_q <= PH_DATA;
               tx_q    <= sh_q[0];
            end
            PH_DATA: if (seg_done) begin
               if (idx_q == w_q - 1'b1) begin
                  phase_q <= par_en_q ? PH_PAR : PH_STOP;
                  tx_q    <= par_en_q ? par_q : 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  sh_q  <= sh_q >> 1;
                  tx_q  <= sh_q[1];
               end
            end
            PH_PAR: if (seg_done) begin
               phase_q <= PH_STOP;
               tx_q    <= 1'b1;
            end
            PH_STOP: if (seg_done) begin
               if (stop_left_q == 3'd1) phase_q <= PH_IDLE;
               else                     stop_left_q <= stop_left_q - 3'd1;
            end
            default: begin
               phase_q <= PH_IDLE;
               tx_q    <= 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/utx_chk.sv
module utx_chk (
   input logic clk,
   input logic rst_n,
   input logic os_tick,
   input logic in_valid,
   input logic in_ready,
   input logic tx_out,
   input logic tx_complete,
   input logic cts_in,
   input logic cfg_cts_en,
   input logic cfg_cts_low,
   input logic cts_feature
);
   p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_complete |-> tx_out);

   p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   p_start_bit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !tx_out);

   p_cts_holds_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_feature && cfg_cts_en && (cts_in == cfg_cts_low)) |-> !in_ready);

   p_complete_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_complete && !cfg_cts_en) |-> in_ready);

   p_line_waits_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!os_tick && !(in_valid && in_ready)) |=> $stable(tx_out));
endmodule

bind utx_core utx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .os_tick     (os_tick),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .tx_out      (tx_out),
   .tx_complete (tx_complete),
   .cts_in      (cts_in),
   .cfg_cts_en  (cfg_cts_en),
   .cfg_cts_low (cfg_cts_low),
   .cts_feature (cts_feature)
);

// File: tb/sim_utx_core.sv
`timescale 1ns/1ps
module sim_utx_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        os_tick = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_ready;
   logic [4:0]  cfg_width = 5'd8;
   logic        cfg_msb_first = 1'b0;
   logic [1:0]  cfg_parity = 2'b00;
   logic [1:0]  cfg_stop_half = 2'd1;
   logic [5:0]  cfg_os = 6'd12;
   logic        cfg_cts_en = 1'b0;
   logic        cfg_cts_low = 1'b1;
   logic        cts_in = 1'b1;
   logic        tx_out, tx_complete;

   int    n_chk = 0, n_bad = 0;
   string cur_req = "R1";
   bit    running = 1'b0;
   int    tick_div = 1, tick_ph = 0;

   always #10 clk = ~clk;

   utx_core u0 (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready), .cfg_width(cfg_width),
      .cfg_msb_first(cfg_msb_first), .cfg_parity(cfg_parity),
      .cfg_stop_half(cfg_stop_half), .cfg_os(cfg_os), .cfg_cts_en(cfg_cts_en),
      .cfg_cts_low(cfg_cts_low), .cts_in(cts_in), .tx_out(tx_out),
      .tx_complete(tx_complete)
   );

   task automatic chk(bit ok, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   // Reference model: a frame is a list of (level, tick count) segments
   int q_lv[$];
   int q_tk[$];
   int rem = 0;
   bit m_tx = 1'b1;
   int m_acc = 0;

   function automatic bit m_cts_ok();
      if (!cfg_cts_en) return 1'b1;
      return cfg_cts_low ? !cts_in : cts_in;
   endfunction

   function automatic void build(logic [15:0] d);
      int w, os, ones, b;
      w  = (cfg_width < 4) ? 4 : ((cfg_width > 16) ? 16 : int'(cfg_width));
      os = (cfg_os < 2) ? 2 : int'(cfg_os);
      ones = 0;
      q_lv.push_back(0); q_tk.push_back(os);
      for (int i = 0; i < w; i++) begin
         b = cfg_msb_first ? int'(d[w-1-i]) : int'(d[i]);
         ones += b;
         q_lv.push_back(b); q_tk.push_back(os);
      end
      if (cfg_parity[1]) begin
         if (cfg_parity[0]) q_lv.push_back((ones % 2 == 0) ? 1 : 0);
         else               q_lv.push_back(ones % 2);
         q_tk.push_back(os);
      end
      for (int h = 0; h <= int'(cfg_stop_half); h++) begin
         q_lv.push_back(1); q_tk.push_back(os / 2);
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q_lv.delete(); q_tk.delete(); m_tx = 1'b1;
      end else if (q_lv.size() == 0) begin
         if (in_valid && m_cts_ok()) begin
            build(in_data);
            m_acc++;
            m_tx = q_lv[0][0];
            rem  = q_tk[0];
         end
      end else if (os_tick) begin
         rem--;
         if (rem == 0) begin
            void'(q_lv.pop_front()); void'(q_tk.pop_front());
            if (q_lv.size() == 0) m_tx = 1'b1;
            else begin m_tx = q_lv[0][0]; rem = q_tk[0]; end
         end
      end
   end

   // Every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (running && rst_n) begin
         chk(tx_out === m_tx, "tx_out (R3)", int'(tx_out), int'(m_tx));
         chk(in_ready === ((q_lv.size() == 0) && m_cts_ok()), "in_ready (R2)",
             int'(in_ready), int'((q_lv.size() == 0) && m_cts_ok()));
         chk(tx_complete === ((q_lv.size() == 0) && !in_valid), "tx_complete (R9)",
             int'(tx_complete), int'((q_lv.size() == 0) && !in_valid));
      end
   end

   // Oversampling enable
   always @(posedge clk) begin
      #5;
      tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
      os_tick = (tick_ph == 0);
   end

   task automatic send(logic [15:0] d);
      int c;
      @(posedge clk); #5;
      in_valid = 1'b1; in_data = d;
      c = m_acc;
      do begin @(posedge clk); #1; end while (m_acc == c);
      #4; in_valid = 1'b0;
   endtask

   task automatic wait_idle();
      do begin @(posedge clk); #1; end while (q_lv.size() != 0);
      repeat (3) @(posedge clk);
   endtask

   task automatic set_cfg(int w, bit msb, logic [1:0] par, logic [1:0] stp, int os);
      @(posedge clk); #5;
      cfg_width = 5'(w); cfg_msb_first = msb; cfg_parity = par;
      cfg_stop_half = stp; cfg_os = 6'(os);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      #5 rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk(tx_out === 1'b1, "reset tx_out", int'(tx_out), 1);
      chk(tx_complete === 1'b1, "reset tx_complete", int'(tx_complete), 1);
      chk(in_ready === 1'b1, "reset in_ready", int'(in_ready), 1);
      running = 1'b1;

      cur_req = "R3";
      send(16'h00A5); send(16'h003C); wait_idle();

      cur_req = "R5";
      set_cfg(8, 1, 2'b00, 2'd1, 12);
      send(16'h00A5); send(16'h0001); wait_idle();

      cur_req = "R6";
      set_cfg(8, 0, 2'b10, 2'd1, 12);
      send(16'h0007); send(16'h0003); wait_idle();
      set_cfg(8, 0, 2'b11, 2'd1, 12);
      send(16'h0007); send(16'h0000); wait_idle();
      set_cfg(8, 0, 2'b01, 2'd1, 12);
      send(16'h00FF); wait_idle();

      cur_req = "R4";
      set_cfg(4, 0, 2'b10, 2'd0, 8);
      send(16'hFFF9); wait_idle();
      set_cfg(16, 1, 2'b11, 2'd0, 8);
      send(16'hC3A1); wait_idle();
      set_cfg(2, 0, 2'b00, 2'd0, 8);
      send(16'h000B); wait_idle();
      set_cfg(20, 0, 2'b00, 2'd0, 8);
      send(16'h8001); wait_idle();

      cur_req = "R7";
      for (int s = 0; s < 4; s++) begin
         set_cfg(5, 0, 2'b00, 2'(s), 7);
         send(16'h0015); wait_idle();
      end
      set_cfg(4, 0, 2'b10, 2'd3, 1);
      send(16'h0006); wait_idle();

      cur_req = "R10";
      tick_div = 3;
      set_cfg(6, 1, 2'b11, 2'd2, 5);
      send(16'h002D); send(16'h0012); wait_idle();
      tick_div = 1;

      cur_req = "R8";
      set_cfg(8, 0, 2'b00, 2'd1, 12);
      @(posedge clk); #5 cfg_cts_en = 1'b1; cfg_cts_low = 1'b1; cts_in = 1'b1;
      fork
         send(16'h005A);
         begin
            repeat (40) @(posedge clk); #5 cts_in = 1'b0;
            repeat (30) @(posedge clk); #5 cts_in = 1'b1;
         end
      join
      wait_idle();
      @(posedge clk); #5 cfg_cts_low = 1'b0; cts_in = 1'b0;
      fork
         send(16'h00C6);
         begin
            repeat (25) @(posedge clk); #5 cts_in = 1'b1;
            repeat (20) @(posedge clk); #5 cts_in = 1'b0;
         end
      join
      wait_idle();
      @(posedge clk); #5 cfg_cts_en = 1'b0;

      cur_req = "R9";
      fork
         send(16'h0081);
         begin #2; end
      join
      send(16'h007E);
      wait_idle();

      running = 1'b0;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule